// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Code Front End

This block is the digital side of a two-channel 12-bit converter. A host writes codes over a parallel bus that is 12 bits wide, or 8 bits wide and MSB-justified. The bus is controlled by active-low strobes. Each channel has two storage stages. The first stage is a staging register loaded by a chip-select and write pair. The second stage is a held code loaded for both channels at once by a transfer pair. Because both channels share one transfer event, two new codes can take effect in the same cycle.

The held codes are offset binary, so midscale is 1000 0000 0000. There are two ways to reach midscale. A persistent clear overwrites both held codes. A temporary mask only forces the outputs while it is applied. Each channel also presents its code in segmented form: the top three bits as a thermometer of seven equally weighted lines, and the lower nine bits in plain binary. Every strobe is sampled on the system clock, and each stage behaves as a register that updates in every cycle its enable is true. A status pin reports a clear strobe that arrives together with a staging write.

Top module: `dual_dac_front`

## Requirements
- R1: `chan_sel`=0 directs staging writes to channel 1 and `chan_sel`=1 to channel 2. The staging register of the other channel is never changed by that write.
- R2: A staging register is written at every clock edge where `cs_n` and `wr_in_n` are both low. At any other edge it holds its value.
- R3: With `wide_mode`=1, a staging write stores bus bits 11..0 unchanged.
- R4: With `wide_mode`=0, a staging write copies bus bits 11..8 into staging bits 3..0 and leaves staging bits 11..4 unchanged.
- R5: At every edge where `wr_xfer_n` and `xfer_n` are both low, both held codes load from their staging registers together. A staging write alone does not change `code_ch1` or `code_ch2`.
- R6: At an edge where `xfer_n` is high and `wr_xfer_n` and `clr_n` are both low, both held codes become 12'h800. They keep that value after the strobes are released, while the staging registers keep their contents.
- R7: After reset, both held codes and both staging registers are 12'h800 and `bad_combo` is 0.
- R8: While `wr_xfer_n`, `xfer_n` and `clr_n` are all low, both code outputs read 12'h800. Once `clr_n` goes high, the outputs show the held codes again.
- R9: With `cs_n`, `wr_in_n`, `wr_xfer_n` and `xfer_n` all held low, a bus value appears on the addressed channel's code output two clock edges after it is driven. The other channel keeps its code.
- R10: With only `cs_n` and `wr_in_n` held low, the code outputs do not change until a transfer pulse. The pulse then latches the current bus word into the addressed channel.
- R11: For each channel, `therm_chN[k]` is 1 exactly when code bits 11..9, read as an unsigned number, exceed k (k = 0..6). `fine_chN` equals code bits 8..0.
- R12: `bad_combo` is 1 in the cycle after any edge where `clr_n`, `cs_n` and `wr_in_n` were all low, and 0 after every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_data | input | 12 | Parallel data bus, bit 11 most significant |
| wide_mode | input | 1 | 1: 12-bit bus, 0: 8-bit MSB-justified bus |
| chan_sel | input | 1 | Channel address for staging writes |
| cs_n | input | 1 | Chip select, active low |
| wr_in_n | input | 1 | Staging write strobe, active low |
| wr_xfer_n | input | 1 | Transfer/clear write strobe, active low |
| xfer_n | input | 1 | Transfer enable, active low |
| clr_n | input | 1 | Clear, active low |
| code_ch1 | output | 12 | Channel 1 output code, offset binary |
| code_ch2 | output | 12 | Channel 2 output code, offset binary |
| therm_ch1 | output | 7 | Channel 1 thermometer of the top three code bits |
| fine_ch1 | output | 9 | Channel 1 lower nine code bits |
| therm_ch2 | output | 7 | Channel 2 thermometer of the top three code bits |
| fine_ch2 | output | 9 | Channel 2 lower nine code bits |
| bad_combo | output | 1 | Clear asserted together with a staging write |

## Verification
Some properties are checked on every cycle. These are: that a staging register holds whenever its write is not enabled, and that narrow-mode writes leave its upper eight bits untouched. They also cover the load and clear results of each held code, that a write to one channel never disturbs the other, that the thermometer lines always form a contiguous run, and the one-cycle timing of the invalid-combination flag. Other behaviours need multi-step stimulus and only the scenarios show them. These are: the two-write assembly of a word from a narrow bus, a mask that lifts to restore the earlier codes, the two-edge latency of full pass-through, transfer-strobe latching with the first stage left open, and a persistent clear after which the staging contents can still be transferred.

// File: rtl/dac_front_pkg.sv
package dac_front_pkg;

  typedef enum logic [1:0] {
    HOLD_KEEP  = 2'd0,
    HOLD_LOAD  = 2'd1,
    HOLD_CLEAR = 2'd2
  } hold_op_e;

endpackage

// File: rtl/dac_in_reg.sv
module dac_in_reg #(
  parameter int CODE_W   = 12,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wide,
  input  logic [CODE_W-1:0] bus,
  output logic [CODE_W-1:0] q
);

  localparam int LOW_W = CODE_W - NARROW_W;
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= MID;
    end else if (wr_en) begin
      if (wide) begin
        q <= bus;
      end else begin
        q[LOW_W-1:0] <= bus[CODE_W-1 -: LOW_W];
      end
    end
  end

  // R2: without a write strobe the staging value is frozen
  p_hold_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));

  // R4: narrow writes never touch the upper part
  p_narrow_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wide) |=> $stable(q[CODE_W-1:LOW_W]));

  // R3: wide writes capture the whole bus
  p_wide_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wide) |=> (q == $past(bus)));

endmodule

// File: rtl/dac_hold_reg.sv
module dac_hold_reg
  import dac_front_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hold_op_e          op,
  input  logic [CODE_W-1:0] d,
  output logic [CODE_W-1:0] q
);

  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= MID;
    end else begin
      case (op)
        HOLD_LOAD:  q <= d;
        HOLD_CLEAR: q <= MID;
        default:    q <= q;
      endcase
    end
  end

  // R5: a transfer copies the staging value
  p_load_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == HOLD_LOAD) |=> (q == $past(d)));

  // R6: a persistent clear lands on midscale
  p_clear_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == HOLD_CLEAR) |=> (q == MID));

  // R5: no transfer, no change
  p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == HOLD_KEEP) |=> $stable(q));

endmodule

// File: rtl/dac_seg_out.sv
module dac_seg_out #(
  parameter int CODE_W   = 12,
  parameter int SEG_BITS = 3
) (
  input  logic [CODE_W-1:0]              code,
  output logic [(2**SEG_BITS)-2:0]       therm,
  output logic [CODE_W-SEG_BITS-1:0]     fine
);

  localparam int THERM_W = (2**SEG_BITS) - 1;
  localparam int FINE_W  = CODE_W - SEG_BITS;

  logic [SEG_BITS-1:0] top;
  logic [THERM_W-1:0]  therm_inc;

  assign top  = code[CODE_W-1 -: SEG_BITS];
  assign fine = code[FINE_W-1:0];

  for (genvar k = 0; k < THERM_W; k++) begin : g_line
    assign therm[k] = (top > SEG_BITS'(k));
  end

  assign therm_inc = therm + THERM_W'(1);

  // R11: lit lines always form one run starting at line 0
  always_comb begin
    p_therm_contig_r11: assert ((therm_inc & therm) == '0);
  end

endmodule

// File: rtl/dual_dac_front.sv
module dual_dac_front
  import dac_front_pkg::*;
#(
  parameter int CODE_W   = 12,
  parameter int NARROW_W = 8,
  parameter int SEG_BITS = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [CODE_W-1:0]               bus_data,
  input  logic                            wide_mode,
  input  logic                            chan_sel,
  input  logic                            cs_n,
  input  logic                            wr_in_n,
  input  logic                            wr_xfer_n,
  input  logic                            xfer_n,
  input  logic                            clr_n,
  output logic [CODE_W-1:0]               code_ch1,
  output logic [CODE_W-1:0]               code_ch2,
  output logic [(2**SEG_BITS)-2:0]        therm_ch1,
  output logic [CODE_W-SEG_BITS-1:0]      fine_ch1,
  output logic [(2**SEG_BITS)-2:0]        therm_ch2,
  output logic [CODE_W-SEG_BITS-1:0]      fine_ch2,
  output logic                            bad_combo
);

  localparam int NCH     = 2;
  localparam int THERM_W = (2**SEG_BITS) - 1;
  localparam int FINE_W  = CODE_W - SEG_BITS;
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  logic     stage_wr;
  logic     xfer_go;
  logic     clr_keep;
  logic     clr_mask;
  hold_op_e hold_op;

  assign stage_wr = !cs_n && !wr_in_n;
  assign xfer_go  = !wr_xfer_n && !xfer_n;
  assign clr_keep = !wr_xfer_n && xfer_n && !clr_n;
  assign clr_mask = xfer_go && !clr_n;

  always_comb begin
    if (xfer_go)       hold_op = HOLD_LOAD;
    else if (clr_keep) hold_op = HOLD_CLEAR;
    else               hold_op = HOLD_KEEP;
  end

  logic [CODE_W-1:0]  stage_q [NCH];
  logic [CODE_W-1:0]  held_q  [NCH];
  logic [CODE_W-1:0]  out_code[NCH];
  logic [THERM_W-1:0] out_therm[NCH];
  logic [FINE_W-1:0]  out_fine[NCH];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic ch_wr;
    assign ch_wr = stage_wr && (chan_sel == 1'(ch));

    dac_in_reg #(.CODE_W(CODE_W), .NARROW_W(NARROW_W)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (ch_wr),
      .wide  (wide_mode),
      .bus   (bus_data),
      .q     (stage_q[ch])
    );

    dac_hold_reg #(.CODE_W(CODE_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (hold_op),
      .d     (stage_q[ch]),
      .q     (held_q[ch])
    );

    assign out_code[ch] = clr_mask ? MID : held_q[ch];

    dac_seg_out #(.CODE_W(CODE_W), .SEG_BITS(SEG_BITS)) u_seg (
      .code  (out_code[ch]),
      .therm (out_therm[ch]),
      .fine  (out_fine[ch])
    );
  end

  assign code_ch1  = out_code[0];
  assign code_ch2  = out_code[1];
  assign therm_ch1 = out_therm[0];
  assign fine_ch1  = out_fine[0];
  assign therm_ch2 = out_therm[1];
  assign fine_ch2  = out_fine[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bad_combo <= 1'b0;
    else        bad_combo <= stage_wr && !clr_n;
  end

  // R1: a write addressed to channel 1 leaves channel 2 staging alone
  p_other_ch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_in_n && !chan_sel) |=> $stable(stage_q[1]));

  // R1: and the reverse
  p_other_ch_b_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_in_n && chan_sel) |=> $stable(stage_q[0]));

  // R12: flag follows the invalid combination by one cycle
  p_flag_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_in_n && !clr_n) |=> bad_combo);

  p_flag_clr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs_n && !wr_in_n && !clr_n) |=> !bad_combo);

  // R6: persistent clear reaches both outputs once the strobes are gone
  p_clear_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_xfer_n && xfer_n && !clr_n) |=> (held_q[0] == MID && held_q[1] == MID));

endmodule

// File: tb/test_dual_dac_front.sv
module test_dual_dac_front;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_data = '0;
  logic        wide_mode = 1'b1;
  logic        chan_sel = 1'b0;
  logic        cs_n = 1'b1;
  logic        wr_in_n = 1'b1;
  logic        wr_xfer_n = 1'b1;
  logic        xfer_n = 1'b1;
  logic        clr_n = 1'b1;
  logic [11:0] code_ch1, code_ch2;
  logic [6:0]  therm_ch1, therm_ch2;
  logic [8:0]  fine_ch1, fine_ch2;
  logic        bad_combo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_dac_front i_dual_dac_front (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .wide_mode(wide_mode),
    .chan_sel(chan_sel), .cs_n(cs_n), .wr_in_n(wr_in_n), .wr_xfer_n(wr_xfer_n),
    .xfer_n(xfer_n), .clr_n(clr_n), .code_ch1(code_ch1), .code_ch2(code_ch2),
    .therm_ch1(therm_ch1), .fine_ch1(fine_ch1), .therm_ch2(therm_ch2),
    .fine_ch2(fine_ch2), .bad_combo(bad_combo)
  );

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cs_n = 1'b1; wr_in_n = 1'b1; wr_xfer_n = 1'b1; xfer_n = 1'b1; clr_n = 1'b1;
    wide_mode = 1'b1;
  endtask

  task automatic stage_write(input logic ch, input logic [11:0] d, input logic wide);
    @(negedge clk);
    chan_sel = ch; bus_data = d; wide_mode = wide; cs_n = 1'b0; wr_in_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1; wr_in_n = 1'b1; wide_mode = 1'b1;
  endtask

  task automatic transfer();
    @(negedge clk);
    wr_xfer_n = 1'b0; xfer_n = 1'b0;
    @(negedge clk);
    wr_xfer_n = 1'b1; xfer_n = 1'b1;
  endtask

  function automatic logic [6:0] therm_of(input logic [11:0] c);
    logic [6:0] t;
    for (int k = 0; k < 7; k++) t[k] = (int'(c[11:9]) > k);
    return t;
  endfunction

  task automatic t_reset();
    check("R7 ch1 after reset", code_ch1, 12'h800);
    check("R7 ch2 after reset", code_ch2, 12'h800);
    check("R7 flag after reset", {11'd0, bad_combo}, 12'h000);
    check("R11 therm midscale", {5'd0, therm_ch1}, 12'h00F);
    check("R11 fine midscale", {3'd0, fine_ch1}, 12'h000);
    transfer();
    check("R7 staging ch1 reset value", code_ch1, 12'h800);
  endtask

  task automatic t_load_both();
    stage_write(1'b0, 12'h123, 1'b1);
    stage_write(1'b1, 12'hABC, 1'b1);
    check("R5 no change before transfer ch1", code_ch1, 12'h800);
    check("R5 no change before transfer ch2", code_ch2, 12'h800);
    transfer();
    check("R1 R3 R5 ch1 loaded", code_ch1, 12'h123);
    check("R1 R3 R5 ch2 loaded", code_ch2, 12'hABC);
  endtask

  task automatic t_strobe_gate();
    @(negedge clk);
    chan_sel = 1'b0; bus_data = 12'hFFF; cs_n = 1'b0; wr_in_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; wr_in_n = 1'b0;
    @(negedge clk);
    idle();
    transfer();
    check("R2 single strobe ignored ch1", code_ch1, 12'h123);
    check("R2 single strobe ignored ch2", code_ch2, 12'hABC);
  endtask

  task automatic t_byte();
    stage_write(1'b1, 12'h5A0, 1'b1);
    stage_write(1'b1, 12'h7E3, 1'b0);
    transfer();
    check("R4 narrow write assembles ch2", code_ch2, 12'h5A7);
    check("R1 ch1 untouched by ch2 write", code_ch1, 12'h123);
  endtask

  task automatic t_seg();
    check("R11 therm ch1 low code", {5'd0, therm_ch1}, {5'd0, therm_of(12'h123)});
    check("R11 fine ch1", {3'd0, fine_ch1}, 12'h123);
    check("R11 therm ch2", {5'd0, therm_ch2}, 12'h003);
    check("R11 fine ch2", {3'd0, fine_ch2}, 12'h1A7);
    stage_write(1'b0, 12'hFFF, 1'b1);
    transfer();
    check("R11 therm full scale", {5'd0, therm_ch1}, 12'h07F);
    check("R11 fine full scale", {3'd0, fine_ch1}, 12'h1FF);
  endtask

  task automatic t_clear();
    @(negedge clk);
    wr_xfer_n = 1'b0; clr_n = 1'b0;
    @(negedge clk);
    idle();
    check("R6 clear ch1", code_ch1, 12'h800);
    check("R6 clear ch2", code_ch2, 12'h800);
    repeat (3) @(negedge clk);
    check("R6 clear persists ch1", code_ch1, 12'h800);
    transfer();
    check("R6 staging kept ch1", code_ch1, 12'hFFF);
    check("R6 staging kept ch2", code_ch2, 12'h5A7);
  endtask

  task automatic t_mask();
    @(negedge clk);
    wr_xfer_n = 1'b0; xfer_n = 1'b0; clr_n = 1'b0;
    @(negedge clk);
    check("R8 mask ch1", code_ch1, 12'h800);
    check("R8 mask ch2", code_ch2, 12'h800);
    check("R8 mask therm", {5'd0, therm_ch2}, 12'h00F);
    clr_n = 1'b1;
    @(negedge clk);
    check("R8 release restores ch1", code_ch1, 12'hFFF);
    check("R8 release restores ch2", code_ch2, 12'h5A7);
    idle();
  endtask

  task automatic t_pass();
    @(negedge clk);
    chan_sel = 1'b0; bus_data = 12'h3C5;
    cs_n = 1'b0; wr_in_n = 1'b0; wr_xfer_n = 1'b0; xfer_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R9 pass through ch1", code_ch1, 12'h3C5);
    chan_sel = 1'b1; bus_data = 12'h9E1;
    @(negedge clk);
    @(negedge clk);
    check("R9 pass through ch2", code_ch2, 12'h9E1);
    check("R9 ch1 kept after address change", code_ch1, 12'h3C5);
    idle();
  endtask

  task automatic t_semi();
    @(negedge clk);
    chan_sel = 1'b0; bus_data = 12'h246; cs_n = 1'b0; wr_in_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R10 open first stage no output change", code_ch1, 12'h3C5);
    wr_xfer_n = 1'b0; xfer_n = 1'b0;
    @(negedge clk);
    wr_xfer_n = 1'b1; xfer_n = 1'b1;
    check("R10 transfer latches ch1", code_ch1, 12'h246);
    check("R10 ch2 unchanged", code_ch2, 12'h9E1);
    idle();
  endtask

  task automatic t_flag();
    @(negedge clk);
    chan_sel = 1'b1; bus_data = 12'h9E1; cs_n = 1'b0; wr_in_n = 1'b0; clr_n = 1'b0;
    @(negedge clk);
    idle();
    check("R12 flag set", {11'd0, bad_combo}, 12'h001);
    @(negedge clk);
    check("R12 flag clears", {11'd0, bad_combo}, 12'h000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_both();
    t_strobe_gate();
    t_byte();
    t_seg();
    t_clear();
    t_mask();
    t_pass();
    t_semi();
    t_flag();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule